// File: doc/BRIEF.md
# Fractional Saturating Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and folds the product into a 40-bit accumulator, either adding or subtracting it, in one registered step per start strobe. The accumulator is a 32-bit working range with 8 guard bits above it. The guard bits absorb the growth of long sums of products.

Four mode inputs shape each step. Fractional mode doubles the product, so that two Q15 operands give a Q31 result. Saturate-multiply mode pins the one product that cannot be represented after doubling, the most negative operand times itself, to the largest positive 32-bit value. The saturation enable clamps an overflowing sum to a bound instead of letting it wrap. The wide-range select chooses whether overflow is judged against the 32-bit range or the full 40-bit range, and it also picks the clamp bounds. A sticky flag records any overflow until a synchronous clear, which also zeroes the accumulator.

Top module: `mac_unit`

## Requirements
- R1: After reset, acc_o is 0, ovf_o is 0 and valid_o is 0.
- R2: With fractional mode clear, a start strobe with op_sub_i=0 adds the sign-extended product a_i*b_i (both taken as two's complement) to the accumulator. The new value appears on acc_o at the clock edge that samples the strobe, and valid_o is 1 for the following cycle only.
- R3: With op_sub_i=1, the product is subtracted from the accumulator instead of added.
- R4: With frac_i=1, the product is multiplied by two before it is accumulated. For example, 0x4000 times 0x4000 contributes 0x20000000.
- R5: When frac_i, satmul_i and sat_en_i are all 1 and both operands are 0x8000, the contribution is 0x7FFFFFFF. If any of the three is 0, the contribution is the exact doubled product +2^31 (0x0080000000 in 40 bits).
- R6: With sat_en_i=1 and wide_i=0, a sum above 2^31-1 sets the accumulator to 0x007FFFFFFF, and a sum below -2^31 sets it to 0xFF80000000.
- R7: With sat_en_i=1 and wide_i=1, a sum above 2^39-1 sets the accumulator to 0x7FFFFFFFFF, and a sum below -2^39 sets it to 0x8000000000.
- R8: With sat_en_i=0, the result is the exact sum taken modulo 2^40, so a run whose intermediate sums wrap still ends on the true value when that value fits.
- R9: ovf_o becomes 1 at the edge that accumulates a sum outside the selected range (32-bit when wide_i=0, 40-bit when wide_i=1), whether or not saturation is on. It then stays 1 until clr_i.
- R10: clr_i=1 sets the accumulator and ovf_o to 0 at the next edge and takes priority over a start strobe in the same cycle. That strobe is dropped and valid_o stays 0.
- R11: In a cycle with neither start_i nor clr_i, the accumulator holds its value and valid_o is 0.
- R12: In wide mode with saturation on, 256 accumulations of the largest-magnitude negative doubled product (0x8000 times 0x7FFF, fractional) fit without setting ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of accumulator and overflow flag |
| start_i | input | 1 | Accumulate strobe (valid in) |
| op_sub_i | input | 1 | 0: add product, 1: subtract product |
| a_i | input | 16 | First operand, two's complement |
| b_i | input | 16 | Second operand, two's complement |
| frac_i | input | 1 | Fractional mode: product doubled |
| satmul_i | input | 1 | Saturate the most-negative squared product |
| sat_en_i | input | 1 | Clamp the accumulator on overflow |
| wide_i | input | 1 | 1: 40-bit range and bounds, 0: 32-bit |
| acc_o | output | 40 | Accumulator value |
| ovf_o | output | 1 | Sticky overflow flag |
| valid_o | output | 1 | One-cycle pulse after an accepted strobe |

## Verification
Some properties are checked on every cycle. The accumulator holds still when idle, the clear wins and zeroes state, the overflow flag stays sticky, valid_o follows the strobe, and a saturating step in 32-bit mode always leaves a value inside the 32-bit range. The corner-product substitution is also checked whenever its three modes and operands line up. The bench's scenarios are what show the values themselves. These include the exact sums and differences, the doubling, the four clamp bounds, the wrap of a 256-step run that cancels back to the true value, and the absence of overflow across 256 full-scale negative products. They are all compared against a wide-integer model.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DATA_W  = 16;
    localparam int GUARD_W = 8;
    localparam int PROD_W  = 2 * DATA_W;
    localparam int ACC_W   = PROD_W + GUARD_W;

    typedef enum logic {
        OP_ACC_ADD = 1'b0,
        OP_ACC_SUB = 1'b1
    } acc_op_e;

    typedef struct packed {
        logic frac;
        logic sat_mul;
        logic sat_en;
        logic wide;
    } mac_mode_t;

    typedef struct packed {
        logic [ACC_W-1:0] value;
        logic             ovf;
    } acc_step_t;

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int OP_W  = DATA_W,
    parameter int EXT_W = ACC_W
) (
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    input  mac_mode_t        mode_i,
    output logic [EXT_W-1:0] prod_o
);
    localparam int RAW_W = 2 * OP_W;

    localparam logic [OP_W-1:0]  MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [EXT_W-1:0] PIN_VAL  =
        {{(EXT_W-RAW_W+1){1'b0}}, {(RAW_W-1){1'b1}}};

    logic signed [RAW_W-1:0] raw;
    logic [EXT_W-1:0]        raw_ext;
    logic [EXT_W-1:0]        scaled;
    logic                    corner;

    assign raw     = $signed(a_i) * $signed(b_i);
    assign raw_ext = {{(EXT_W-RAW_W){raw[RAW_W-1]}}, raw};
    assign corner  = (a_i == MOST_NEG) && (b_i == MOST_NEG);

    generate
        if (EXT_W > RAW_W) begin : g_guarded
            assign scaled = mode_i.frac ? {raw_ext[EXT_W-2:0], 1'b0} : raw_ext;
        end else begin : g_flush
            assign scaled = mode_i.frac ? {raw[RAW_W-2:0], 1'b0} : raw_ext;
        end
    endgenerate

    always_comb begin
        if (corner && mode_i.frac && mode_i.sat_mul && mode_i.sat_en) begin
            prod_o = PIN_VAL;
        end else begin
            prod_o = scaled;
        end
    end

endmodule

// File: rtl/mac_step.sv
module mac_step
    import mac_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int NW = PROD_W
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] prod_i,
    input  acc_op_e       op_i,
    input  mac_mode_t     mode_i,
    output acc_step_t     step_o
);
    localparam int XW = AW + 2;

    localparam logic signed [XW-1:0] W_MAX = {{(XW-AW+1){1'b0}}, {(AW-1){1'b1}}};
    localparam logic signed [XW-1:0] W_MIN = {{(XW-AW+1){1'b1}}, {(AW-1){1'b0}}};
    localparam logic signed [XW-1:0] N_MAX = {{(XW-NW+1){1'b0}}, {(NW-1){1'b1}}};
    localparam logic signed [XW-1:0] N_MIN = {{(XW-NW+1){1'b1}}, {(NW-1){1'b0}}};

    logic signed [XW-1:0] acc_x;
    logic signed [XW-1:0] prod_x;
    logic signed [XW-1:0] exact;
    logic signed [XW-1:0] hi_bound;
    logic signed [XW-1:0] lo_bound;
    logic                 out_hi;
    logic                 out_lo;

    assign acc_x  = {{2{acc_i[AW-1]}}, acc_i};
    assign prod_x = {{2{prod_i[AW-1]}}, prod_i};

    always_comb begin
        if (op_i == OP_ACC_SUB) begin
            exact = acc_x - prod_x;
        end else begin
            exact = acc_x + prod_x;
        end
    end

    assign hi_bound = mode_i.wide ? W_MAX : N_MAX;
    assign lo_bound = mode_i.wide ? W_MIN : N_MIN;
    assign out_hi   = exact > hi_bound;
    assign out_lo   = exact < lo_bound;

    always_comb begin
        step_o.ovf = out_hi || out_lo;
        if (mode_i.sat_en && out_hi) begin
            step_o.value = hi_bound[AW-1:0];
        end else if (mode_i.sat_en && out_lo) begin
            step_o.value = lo_bound[AW-1:0];
        end else begin
            step_o.value = exact[AW-1:0];
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic              op_sub_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              frac_i,
    input  logic              satmul_i,
    input  logic              sat_en_i,
    input  logic              wide_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              ovf_o,
    output logic              valid_o
);
    mac_mode_t        mode;
    acc_op_e          op;
    logic [ACC_W-1:0] prod_ext;
    acc_step_t        step;
    logic [ACC_W-1:0] acc_q;
    logic             ovf_q;
    logic             vld_q;

    assign mode.frac    = frac_i;
    assign mode.sat_mul = satmul_i;
    assign mode.sat_en  = sat_en_i;
    assign mode.wide    = wide_i;
    assign op           = op_sub_i ? OP_ACC_SUB : OP_ACC_ADD;

    mac_product #(.OP_W(DATA_W), .EXT_W(ACC_W)) u_prod (
        .a_i    (a_i),
        .b_i    (b_i),
        .mode_i (mode),
        .prod_o (prod_ext)
    );

    mac_step #(.AW(ACC_W), .NW(PROD_W)) u_step (
        .acc_i  (acc_q),
        .prod_i (prod_ext),
        .op_i   (op),
        .mode_i (mode),
        .step_o (step)
    );

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= start_i;
            if (start_i) begin
                acc_q <= step.value;
                ovf_q <= ovf_q | step.ovf;
            end
        end
    end

    assign acc_o   = acc_q;
    assign ovf_o   = ovf_q;
    assign valid_o = vld_q;

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
    import mac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clr_i,
    input logic              start_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              frac_i,
    input logic              satmul_i,
    input logic              sat_en_i,
    input logic              wide_i,
    input logic [ACC_W-1:0]  prod_ext,
    input logic [ACC_W-1:0]  acc_o,
    input logic              ovf_o,
    input logic              valid_o
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [ACC_W-1:0]  PIN_VAL  = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc_o == '0) && !ovf_o && !valid_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !clr_i) |=> $stable(acc_o) && !valid_o);

    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !clr_i) |=> ovf_o);

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !clr_i) |=> valid_o);

    // R6
    narrow_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !clr_i && sat_en_i && !wide_i) |=>
            ((&acc_o[ACC_W-1:PROD_W-1]) || !(|acc_o[ACC_W-1:PROD_W-1])));

    // R5
    corner_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (frac_i && satmul_i && sat_en_i && a_i == MOST_NEG && b_i == MOST_NEG)
            |-> prod_ext == PIN_VAL);

endmodule

bind mac_unit mac_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_i),
    .start_i  (start_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .frac_i   (frac_i),
    .satmul_i (satmul_i),
    .sat_en_i (sat_en_i),
    .wide_i   (wide_i),
    .prod_ext (prod_ext),
    .acc_o    (acc_o),
    .ovf_o    (ovf_o),
    .valid_o  (valid_o)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic        start_i = 1'b0;
    logic        op_sub_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        frac_i = 1'b0;
    logic        satmul_i = 1'b0;
    logic        sat_en_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [39:0] acc_o;
    logic        ovf_o;
    logic        valid_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    longint m_acc = 0;
    bit     m_ovf = 1'b0;

    always #5 clk = ~clk;

    mac_unit u_dut (
        .clk(clk), .rst(rst), .clr_i(clr_i), .start_i(start_i),
        .op_sub_i(op_sub_i), .a_i(a_i), .b_i(b_i), .frac_i(frac_i),
        .satmul_i(satmul_i), .sat_en_i(sat_en_i), .wide_i(wide_i),
        .acc_o(acc_o), .ovf_o(ovf_o), .valid_o(valid_o)
    );

    function automatic longint wrap40(input longint v);
        longint r;
        r = v & ((64'sd1 <<< 40) - 1);
        if (r >= (64'sd1 <<< 39)) r = r - (64'sd1 <<< 40);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag, input bit exp_valid);
        longint exp40;
        exp40 = m_acc & ((64'sd1 <<< 40) - 1);
        check(acc_o == exp40[39:0], tag, "acc", longint'(acc_o), exp40);
        check(ovf_o == m_ovf, tag, "ovf", longint'(ovf_o), longint'(m_ovf));
        check(valid_o == exp_valid, tag, "valid", longint'(valid_o), longint'(exp_valid));
    endtask

    task automatic do_op(input logic [15:0] a, input logic [15:0] b, input bit sub,
                         input bit fr, input bit sm, input bit st, input bit wd,
                         input string tag);
        longint p, e, hi, lo;
        bit     ov;
        a_i = a; b_i = b; op_sub_i = sub; frac_i = fr; satmul_i = sm;
        sat_en_i = st; wide_i = wd; start_i = 1'b1;
        p = longint'($signed(a)) * longint'($signed(b));
        if (fr) p = p * 2;
        if (fr && sm && st && a == 16'h8000 && b == 16'h8000) p = 64'sh7FFF_FFFF;
        e  = sub ? (m_acc - p) : (m_acc + p);
        hi = wd ? ((64'sd1 <<< 39) - 1) : ((64'sd1 <<< 31) - 1);
        lo = wd ? -(64'sd1 <<< 39) : -(64'sd1 <<< 31);
        ov = (e > hi) || (e < lo);
        if (ov) m_ovf = 1'b1;
        if (st && e > hi)      m_acc = hi;
        else if (st && e < lo) m_acc = lo;
        else                   m_acc = wrap40(e);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        compare(tag, 1'b1);
    endtask

    task automatic do_clear(input string tag);
        clr_i = 1'b1;
        start_i = 1'b1;
        a_i = 16'h1234; b_i = 16'h0101;
        @(posedge clk);
        @(negedge clk);
        clr_i = 1'b0;
        start_i = 1'b0;
        m_acc = 0;
        m_ovf = 1'b0;
        compare(tag, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1", 1'b0);

        do_op(16'd3, 16'd5, 1'b0, 0, 0, 0, 1, "R2");
        do_op(16'hFFF9, 16'd100, 1'b0, 0, 0, 0, 1, "R2");
        check(acc_o == 40'hFF_FFFF_FD53, "R2", "literal -685", longint'(acc_o), 64'hFF_FFFF_FD53);
        do_op(16'd2, 16'd3, 1'b1, 0, 0, 0, 1, "R3");
        do_op(16'h8000, 16'h7FFF, 1'b1, 0, 0, 1, 1, "R3");

        repeat (3) begin
            @(negedge clk);
            compare("R11", 1'b0);
        end

        do_clear("R10");

        do_op(16'h4000, 16'h4000, 1'b0, 1, 0, 0, 1, "R4");
        check(acc_o == 40'h00_2000_0000, "R4", "literal", longint'(acc_o), 64'h2000_0000);

        do_clear("R10");
        do_op(16'h8000, 16'h8000, 1'b0, 1, 1, 1, 0, "R5");
        check(acc_o == 40'h00_7FFF_FFFF, "R5", "pinned", longint'(acc_o), 64'h7FFF_FFFF);
        do_clear("R10");
        do_op(16'h8000, 16'h8000, 1'b0, 1, 0, 1, 1, "R5");
        check(acc_o == 40'h00_8000_0000, "R5", "exact", longint'(acc_o), 64'h8000_0000);

        do_clear("R10");
        do_op(16'h7FFF, 16'h7FFF, 1'b0, 1, 0, 1, 0, "R6");
        do_op(16'h7FFF, 16'h7FFF, 1'b0, 1, 0, 1, 0, "R6");
        check(acc_o == 40'h00_7FFF_FFFF, "R6", "pos clamp", longint'(acc_o), 64'h7FFF_FFFF);
        do_op(16'd1, 16'd1, 1'b1, 0, 0, 1, 0, "R9");
        check(ovf_o == 1'b1, "R9", "sticky", longint'(ovf_o), 1);
        do_clear("R10");
        do_op(16'h8000, 16'h7FFF, 1'b0, 1, 0, 1, 0, "R6");
        do_op(16'h8000, 16'h7FFF, 1'b0, 1, 0, 1, 0, "R6");
        check(acc_o == 40'hFF_8000_0000, "R6", "neg clamp", longint'(acc_o), 64'hFF_8000_0000);

        do_clear("R10");
        for (int k = 0; k < 256; k++) do_op(16'h8000, 16'h7FFF, 1'b0, 1, 0, 1, 1, "R12");
        check(ovf_o == 1'b0, "R12", "no ovf after 256", longint'(ovf_o), 0);
        do_op(16'h8000, 16'h7FFF, 1'b0, 1, 0, 1, 1, "R7");
        check(acc_o == 40'h80_0000_0000, "R7", "neg clamp", longint'(acc_o), 64'h80_0000_0000);

        do_clear("R10");
        for (int k = 0; k < 256; k++) do_op(16'h8000, 16'h8000, 1'b0, 1, 0, 1, 1, "R7");
        check(acc_o == 40'h7F_FFFF_FFFF, "R7", "pos clamp", longint'(acc_o), 64'h7F_FFFF_FFFF);

        do_clear("R10");
        for (int k = 0; k < 256; k++) do_op(16'h8000, 16'h8000, 1'b0, 1, 0, 0, 1, "R8");
        check(acc_o == 40'h80_0000_0000, "R8", "wrapped", longint'(acc_o), 64'h80_0000_0000);
        for (int k = 0; k < 255; k++) do_op(16'h8000, 16'h8000, 1'b1, 1, 0, 0, 1, "R8");
        check(acc_o == 40'h00_8000_0000, "R8", "cancelled", longint'(acc_o), 64'h8000_0000);
        check(ovf_o == 1'b1, "R9", "flag after wrap", longint'(ovf_o), 1);

        do_clear("R10");
        @(negedge clk);
        compare("R11", 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule